// File: doc/BRIEF.md
# Four-Tone Frequency Correlating Detector

This block recovers two data bits per symbol from a frequency-hopped, four-tone
signal after it has been mixed to zero frequency and hard-limited to one bit in
two quadrature channels. It runs at a fixed rate of SPS samples per symbol. It
builds its own square-wave references at the symbol rate and at twice the symbol
rate, each in two phases a quarter period apart. It correlates both input bits
against all four references with integrate-and-dump counters.

At every symbol-start strobe the counters are dumped and cleared. The block
combines the dumped coefficients into one energy figure for each of the four
candidate offsets: above and below the centre, at one and two cycles per symbol.
It registers the index of the largest figure as a Gray-coded 2-bit decision,
together with a one-cycle valid pulse. Symbol timing comes from outside through
the strobe.

Top module: `fsk4_corr_det`

## Requirements
- R1: While reset is asserted and until the first strobe has been sampled, `valid_o` is 0 and `decision_o` is 2'b00.
- R2: The sample phase p is 0 in a cycle with `sym_start_i` high, otherwise the previous phase plus 1, wrapping from SPS-1 to 0. The slow in-phase reference is 1 for p < SPS/2. The slow quadrature reference is 1 for SPS/4 <= p < 3*SPS/4. With p2 = p mod SPS/2, the fast in-phase reference is 1 for p2 < SPS/4, and the fast quadrature reference is 1 for SPS/8 <= p2 < 3*SPS/8.
- R3: Each of the eight coefficients (two inputs by four references) moves by +1 on a sample where input and reference are equal and by -1 where they differ. In a strobe cycle the previous value is dumped and the count restarts from zero with that cycle's sample.
- R4: A coefficient saturates at +/-(2^(CW-1)-1) and never wraps when strobes are late.
- R5: For each reference rate, II, IQ, QI and QQ are the coefficients of the I or Q input against the in-phase or quadrature reference. The upper-offset energy is |II+QQ|+|QI-IQ|. The lower-offset energy is |II-QQ|+|QI+IQ|.
- R6: An upper-offset tone arrives as I equal to the in-phase reference and Q equal to the quadrature reference. A lower-offset tone arrives with Q inverted. The codes are: upper fast 2'b10, upper slow 2'b11, lower slow 2'b01, lower fast 2'b00.
- R7: On equal energies, the decision goes to the earliest of: upper fast, upper slow, lower slow, lower fast.
- R8: `valid_o` is high for exactly the one cycle after each cycle in which `sym_start_i` is high. `decision_o` changes in that same cycle.
- R9: `decision_o` holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, SPS cycles per symbol |
| rst_ni | input | 1 | Asynchronous reset, active low |
| i_bit_i | input | 1 | Hard-limited in-phase sample |
| q_bit_i | input | 1 | Hard-limited quadrature sample |
| sym_start_i | input | 1 | First sample of a new symbol |
| decision_o | output | 2 | Gray-coded tone decision |
| valid_o | output | 1 | Decision strobe |

## Verification
The bench goes after tie cases: a constant input, where all four energies are zero, and single-channel slow or fast tones, which split energy equally between the upper and lower offsets. A wrong tie order would report the lower offset or a slow code there. A symbol cut short by an early strobe, followed by a full tone, exposes counters that are not cleared or a phase that does not restart: the next decision would be corrupted. An overlong symbol without a strobe stresses saturation. Noisy samples check that a few flipped bits do not change the decision. Pure tones of all four kinds pin down the code map and the sign of the quadrature lag.

// File: rtl/fsk4_pkg.sv
package fsk4_pkg;
  localparam int unsigned NREF = 4;  // slow-I, slow-Q, fast-I, fast-Q
  localparam int unsigned NIN  = 2;  // I, Q
  localparam int unsigned NACC = NIN * NREF;

  typedef enum logic [1:0] {
    TONE_UP_FAST = 2'd0,
    TONE_UP_SLOW = 2'd1,
    TONE_DN_SLOW = 2'd2,
    TONE_DN_FAST = 2'd3
  } tone_idx_e;

  function automatic logic [1:0] tone_code(input tone_idx_e t);
    case (t)
      TONE_UP_FAST: tone_code = 2'b10;
      TONE_UP_SLOW: tone_code = 2'b11;
      TONE_DN_SLOW: tone_code = 2'b01;
      default:      tone_code = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/fsk4_ref_gen.sv
module fsk4_ref_gen #(
  parameter int unsigned SPS = 88,
  localparam int unsigned PW = $clog2(SPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sym_start_i,
  output logic [PW-1:0] phase_o,
  output logic [3:0]    ref_o
);
  localparam int unsigned HALF1 = SPS / 2;
  localparam int unsigned QTR1  = SPS / 4;
  localparam int unsigned HALF2 = SPS / 4;
  localparam int unsigned QTR2  = SPS / 8;

  logic [PW-1:0] cnt_q, ph, ph2;

  assign ph = sym_start_i ? '0 : cnt_q;
  assign ph2 = (ph >= PW'(HALF1)) ? ph - PW'(HALF1) : ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (ph == PW'(SPS - 1)) cnt_q <= '0;
    else cnt_q <= ph + PW'(1);
  end

  assign ref_o[0] = ph < PW'(HALF1);
  assign ref_o[1] = (ph >= PW'(QTR1)) && (ph < PW'(QTR1 + HALF1));
  assign ref_o[2] = ph2 < PW'(HALF2);
  assign ref_o[3] = (ph2 >= PW'(QTR2)) && (ph2 < PW'(QTR2 + HALF2));
  assign phase_o = cnt_q;
endmodule

// File: rtl/fsk4_acc.sv
module fsk4_acc #(
  parameter int unsigned CW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 agree_i,
  output logic signed [CW-1:0] coef_o
);
  localparam logic signed [CW-1:0] SAT_HI = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] SAT_LO = -SAT_HI;

  logic signed [CW-1:0] base, nxt;

  assign base = clr_i ? '0 : coef_o;

  always_comb begin
    if (agree_i) nxt = (base == SAT_HI) ? base : base + CW'(1);
    else         nxt = (base == SAT_LO) ? base : base - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_o <= '0;
    else coef_o <= nxt;
  end
endmodule

// File: rtl/fsk4_decide.sv
module fsk4_decide
  import fsk4_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       dump_i,
  input  logic [NACC-1:0][CW-1:0]    coef_i,
  output logic [1:0]                 decision_o,
  output logic                       valid_o
);
  localparam int unsigned SW = CW + 1;
  localparam int unsigned EW = CW + 2;

  function automatic logic [SW-1:0] mag(input logic signed [SW-1:0] v);
    mag = v[SW-1] ? -v : v;
  endfunction

  logic [1:0][EW-1:0] e_up, e_dn;

  for (genvar f = 0; f < 2; f++) begin : g_rate
    logic signed [SW-1:0] ii, iq, qi, qq;
    assign ii = SW'($signed(coef_i[2*f]));
    assign iq = SW'($signed(coef_i[2*f+1]));
    assign qi = SW'($signed(coef_i[NREF+2*f]));
    assign qq = SW'($signed(coef_i[NREF+2*f+1]));
    assign e_up[f] = EW'(mag(ii + qq)) + EW'(mag(qi - iq));
    assign e_dn[f] = EW'(mag(ii - qq)) + EW'(mag(qi + iq));
  end

  logic [3:0][EW-1:0] cand;
  assign cand[TONE_UP_FAST] = e_up[1];
  assign cand[TONE_UP_SLOW] = e_up[0];
  assign cand[TONE_DN_SLOW] = e_dn[0];
  assign cand[TONE_DN_FAST] = e_dn[1];

  tone_idx_e best;
  always_comb begin
    best = TONE_UP_FAST;
    for (int k = 1; k < 4; k++)
      if (cand[k] > cand[best]) best = tone_idx_e'(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decision_o <= 2'b00;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= dump_i;
      if (dump_i) decision_o <= tone_code(best);
    end
  end
endmodule

// File: rtl/fsk4_corr_det.sv
module fsk4_corr_det
  import fsk4_pkg::*;
#(
  parameter int unsigned SPS = 88,
  parameter int unsigned CW  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       i_bit_i,
  input  logic       q_bit_i,
  input  logic       sym_start_i,
  output logic [1:0] decision_o,
  output logic       valid_o
);
  localparam int unsigned PW = $clog2(SPS);

  logic [PW-1:0]          phase_q;
  logic [NREF-1:0]        refs;
  logic [NACC-1:0][CW-1:0] coef;
  logic [NIN-1:0]         bits;

  assign bits = {q_bit_i, i_bit_i};

  fsk4_ref_gen #(.SPS(SPS)) u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_start_i (sym_start_i),
    .phase_o     (phase_q),
    .ref_o       (refs)
  );

  for (genvar n = 0; n < NIN; n++) begin : g_in
    for (genvar r = 0; r < NREF; r++) begin : g_ref
      logic signed [CW-1:0] c;
      fsk4_acc #(.CW(CW)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (sym_start_i),
        .agree_i (bits[n] == refs[r]),
        .coef_o  (c)
      );
      assign coef[n*NREF+r] = c;
    end
  end

  fsk4_decide #(.CW(CW)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dump_i     (sym_start_i),
    .coef_i     (coef),
    .decision_o (decision_o),
    .valid_o    (valid_o)
  );
endmodule

// File: rtl/fsk4_corr_det_chk.sv
module fsk4_corr_det_chk
  import fsk4_pkg::*;
#(
  parameter int unsigned SPS = 88,
  parameter int unsigned CW  = 8,
  localparam int unsigned PW = $clog2(SPS)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sym_start_i,
  input logic                    valid_o,
  input logic [1:0]              decision_o,
  input logic [NACC-1:0][CW-1:0] coef,
  input logic [PW-1:0]           phase_q
);
  a_r8_valid_follows_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_i |=> valid_o);
  a_r8_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_start_i |=> !valid_o);
  a_r9_decision_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_start_i |=> $stable(decision_o));
  a_r2_phase_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_i |=> (phase_q == PW'(1)));
  a_r2_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < PW'(SPS));

  for (genvar k = 0; k < NACC; k++) begin : g_c
    a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sym_start_i |=> (coef[k] == CW'(1) || coef[k] == {CW{1'b1}}));
    a_r3_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sym_start_i |=> (coef[k] == $past(coef[k]) + CW'(1) ||
                        coef[k] == $past(coef[k]) - CW'(1) || $stable(coef[k])));
    a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      coef[k] != {1'b1, {(CW-1){1'b0}}});
  end
endmodule

bind fsk4_corr_det fsk4_corr_det_chk #(.SPS(SPS), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_start_i (sym_start_i),
  .valid_o     (valid_o),
  .decision_o  (decision_o),
  .coef        (coef),
  .phase_q     (phase_q)
);

// File: tb/fsk4_corr_det_tb.sv
module fsk4_corr_det_tb;
  localparam int SPS = 88;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_bit = 1'b0, q_bit = 1'b0, sym = 1'b0;
  logic [1:0] decision;
  logic valid;
  int n_chk = 0, n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fsk4_corr_det #(.SPS(SPS), .CW(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .i_bit_i(i_bit), .q_bit_i(q_bit),
    .sym_start_i(sym), .decision_o(decision), .valid_o(valid)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // square references per R2: f=0 slow, f=1 fast; q selects quadrature
  function automatic logic sq(input int f, input logic q, input int n);
    int per = f ? SPS/2 : SPS;
    int p = n % per;
    int h = per/2, qt = per/4;
    return q ? (p >= qt && p < qt + h) : (p < h);
  endfunction

  // kinds: 0 up fast,1 up slow,2 dn slow,3 dn fast,4 const,5 I slow Q=1,
  // 6 I fast Q=1, 7 junk, 8 noisy up fast
  function automatic logic [1:0] gen(input int kind, input int n);
    logic iv, qv;
    case (kind)
      0: begin iv = sq(1,0,n); qv = sq(1,1,n); end
      1: begin iv = sq(0,0,n); qv = sq(0,1,n); end
      2: begin iv = sq(0,0,n); qv = ~sq(0,1,n); end
      3: begin iv = sq(1,0,n); qv = ~sq(1,1,n); end
      4: begin iv = 1'b1; qv = 1'b1; end
      5: begin iv = sq(0,0,n); qv = 1'b1; end
      6: begin iv = sq(1,0,n); qv = 1'b1; end
      7: begin iv = ((n*7) % 3) == 1; qv = ((n*5) % 4) < 2; end
      default: begin iv = sq(1,0,n) ^ ((n % 9) == 4); qv = sq(1,1,n) ^ ((n % 13) == 6); end
    endcase
    return {iv, qv};
  endfunction

  // drives one symbol; the strobe on its first sample dumps the previous one
  task automatic symbol(input int kind, input int len, input bit chk,
                        input logic [1:0] exp, input string req);
    for (int n = 0; n < len; n++) begin
      logic [1:0] b;
      @(negedge clk);
      b = gen(kind, n);
      sym = (n == 0);
      i_bit = b[1];
      q_bit = b[0];
      if (chk && n == 0) begin
        @(posedge clk); #2;
        check({req, " R8 valid"}, {1'b0, valid}, 2'b01);
        check(req, decision, exp);
      end
      if (chk && n == 1) begin
        @(posedge clk); #2;
        check({req, " R8 pulse width"}, {1'b0, valid}, 2'b00);
      end
      if (chk && n == 40) check({req, " R9 hold"}, decision, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {1'b0, valid}, 2'b00);
    check("R1 reset decision", decision, 2'b00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle valid", {1'b0, valid}, 2'b00);
    check("R1 idle decision", decision, 2'b00);

    symbol(0, SPS, 0, 2'b00, "");
    symbol(1, SPS, 1, 2'b10, "R6 up fast");
    symbol(2, SPS, 1, 2'b11, "R6 up slow");
    symbol(3, SPS, 1, 2'b01, "R6 dn slow");
    symbol(4, SPS, 1, 2'b00, "R6 R5 dn fast");
    symbol(5, SPS, 1, 2'b10, "R7 tie all zero");
    symbol(6, SPS, 1, 2'b11, "R7 tie slow");
    symbol(8, SPS, 1, 2'b10, "R7 tie fast");
    symbol(7, 30, 1, 2'b10, "R5 noisy up fast");
    symbol(3, SPS, 0, 2'b00, "");
    symbol(1, 200, 1, 2'b00, "R3 R2 restart after short symbol");
    symbol(2, SPS, 1, 2'b11, "R4 overlong up slow");
    symbol(4, 3, 1, 2'b01, "R3 dn slow after overlong");

    @(negedge clk);
    sym = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule